// File: doc/BRIEF.md
# Multichannel MAC Interrupt Vector Unit

This unit gathers completion events from a bank of transmit channels and a bank of receive channels, plus two MAC-level events (host error and status change), and folds them into one interrupt line. Every source owns a sticky pending bit, set by a one-cycle event pulse and cleared by a matching acknowledge pulse. Three enable masks, one per source group, decide which pending bits reach the interrupt line and the vector word. Each mask has a write-one-to-set address and a write-one-to-clear address.

Software reads a vector word that carries four class flags and the number of the lowest pending enabled channel in each direction. After servicing, software writes the end-of-interrupt address. The line is latched high once raised and only drops on that write. One cycle later it rises again if enabled work is still pending.

Top module: `mac_irq_vector`

## Requirements
- R1: After synchronous reset, irq is 0, all pending bits and all three enable masks are 0, and a read of any address returns 0.
- R2: A write to word address 0x0 / 0x2 / 0x4 ORs reg_wdata into the transmit / receive / MAC enable mask. A write to 0x1 / 0x3 / 0x5 clears the mask bits where reg_wdata is 1. A read of either address of a pair returns that mask. MAC enable bit 0 is host error and bit 1 is status.
- R3: An event pulse sets the source's pending bit at that clock edge. An acknowledge pulse clears it. When event and acknowledge coincide, the event wins.
- R4: A read of address 0x6 returns the vector word. Bit 16 means a transmit channel is pending and enabled, bit 17 the same for receive, bit 18 host error and bit 19 status. Bits 2:0 hold the transmit channel number and bits 10:8 the receive channel number. Each number is 0 when its class has nothing pending, and all other bits are 0.
- R5: When several enabled channels of a direction are pending, the vector reports the lowest-numbered one.
- R6: A disabled source still latches its pending bit, but it neither drives irq nor appears in the vector. Enabling it later exposes it.
- R7: irq rises on the clock edge after an enabled pending source exists. It then stays high until an end-of-interrupt write, even if every source is acknowledged or disabled in between.
- R8: A write to address 0x7 with any data is the end-of-interrupt. irq is 0 after that edge, and it is 1 again after the following edge if any enabled source is still pending.
- R9: Writing all ones to a clear address disables every source of that group. Mask bits beyond a group's width are ignored, so the MAC mask holds at most 0x3.
- R10: Read data is registered: reg_rdata shows the value for the address presented before the latest clock edge. Addresses 0x8 and above read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_done_evt | input | N_CH | Transmit completion pulses, one per channel |
| rx_done_evt | input | N_CH | Receive completion pulses, one per channel |
| tx_done_ack | input | N_CH | Transmit pending clear pulses |
| rx_done_ack | input | N_CH | Receive pending clear pulses |
| host_err_evt | input | 1 | Host error event pulse |
| status_evt | input | 1 | Status event pulse |
| host_err_ack | input | 1 | Host error pending clear |
| status_ack | input | 1 | Status pending clear |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | N_CH | Register write data (mask bits) |
| reg_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Latched interrupt line |

## Verification
A stimulus table drives single-channel events, multi-channel bursts in both directions, each MAC class alone, and partial or empty enable masks. Comparing the vector across these rows separates a correct lowest-channel pick from a highest-channel pick, and correct field placement from swapped direction or class bits. The rows also show whether masking takes effect in both the flags and the channel fields. Directed sequences then cover the rest. These are an event and an acknowledge in the same cycle, a disabled pending source that is enabled later, and acknowledgement while irq is still held. They also include the one-cycle dip and re-rise around an end-of-interrupt write and mask writes with out-of-range bits.

// File: rtl/mivu_pkg.sv
package mivu_pkg;
  localparam int unsigned OFS_TX_SET  = 0;
  localparam int unsigned OFS_TX_CLR  = 1;
  localparam int unsigned OFS_RX_SET  = 2;
  localparam int unsigned OFS_RX_CLR  = 3;
  localparam int unsigned OFS_MAC_SET = 4;
  localparam int unsigned OFS_MAC_CLR = 5;
  localparam int unsigned OFS_VECTOR  = 6;
  localparam int unsigned OFS_EOI     = 7;

  localparam int unsigned VB_TXCH = 0;
  localparam int unsigned VB_RXCH = 8;
  localparam int unsigned VB_TX   = 16;
  localparam int unsigned VB_RX   = 17;
  localparam int unsigned VB_HOST = 18;
  localparam int unsigned VB_STAT = 19;

  localparam int unsigned MAC_SRCS = 2;
endpackage

// File: rtl/mivu_src_bank.sv
module mivu_src_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] ack,
  input  logic [W-1:0] en_set,
  input  logic [W-1:0] en_clr,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] live_o
);
  logic [W-1:0] pend_q;
  logic [W-1:0] en_q;

  generate
    for (genvar i = 0; i < W; i++) begin : g_src
      always_ff @(posedge clk) begin
        if (rst)         pend_q[i] <= 1'b0;
        else if (evt[i]) pend_q[i] <= 1'b1;
        else if (ack[i]) pend_q[i] <= 1'b0;
      end

      always_ff @(posedge clk) begin
        if (rst)            en_q[i] <= 1'b0;
        else if (en_clr[i]) en_q[i] <= 1'b0;
        else if (en_set[i]) en_q[i] <= 1'b1;
      end

      AST_PEND_SET: assert property (@(posedge clk) disable iff (rst)
        evt[i] |=> pend_q[i]);                                     // R3
      AST_PEND_ACK: assert property (@(posedge clk) disable iff (rst)
        (ack[i] && !evt[i]) |=> !pend_q[i]);                       // R3
      AST_EN_CLEARED: assert property (@(posedge clk) disable iff (rst)
        en_clr[i] |=> !en_q[i]);                                   // R9
    end
  endgenerate

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign live_o = pend_q & en_q;
endmodule

// File: rtl/mivu_lowest.sv
module mivu_lowest #(
  parameter int unsigned W  = 8,
  parameter int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/mivu_regif.sv
module mivu_regif
  import mivu_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_CH   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [N_CH-1:0]     reg_wdata,
  input  logic [N_CH-1:0]     tx_en,
  input  logic [N_CH-1:0]     rx_en,
  input  logic [MAC_SRCS-1:0] mac_en,
  input  logic [DATA_W-1:0]   vec,
  output logic [N_CH-1:0]     tx_set,
  output logic [N_CH-1:0]     tx_clr,
  output logic [N_CH-1:0]     rx_set,
  output logic [N_CH-1:0]     rx_clr,
  output logic [MAC_SRCS-1:0] mac_set,
  output logic [MAC_SRCS-1:0] mac_clr,
  output logic                eoi,
  output logic [DATA_W-1:0]   rdata
);
  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned ofs);
    return a == ADDR_W'(ofs);
  endfunction

  always_comb begin
    tx_set  = (reg_wr && hit(reg_addr, OFS_TX_SET))  ? reg_wdata : '0;
    tx_clr  = (reg_wr && hit(reg_addr, OFS_TX_CLR))  ? reg_wdata : '0;
    rx_set  = (reg_wr && hit(reg_addr, OFS_RX_SET))  ? reg_wdata : '0;
    rx_clr  = (reg_wr && hit(reg_addr, OFS_RX_CLR))  ? reg_wdata : '0;
    mac_set = (reg_wr && hit(reg_addr, OFS_MAC_SET)) ? reg_wdata[MAC_SRCS-1:0] : '0;
    mac_clr = (reg_wr && hit(reg_addr, OFS_MAC_CLR)) ? reg_wdata[MAC_SRCS-1:0] : '0;
    eoi     = reg_wr && hit(reg_addr, OFS_EOI);
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit(reg_addr, OFS_TX_SET)  || hit(reg_addr, OFS_TX_CLR))  rd_mux = DATA_W'(tx_en);
    if (hit(reg_addr, OFS_RX_SET)  || hit(reg_addr, OFS_RX_CLR))  rd_mux = DATA_W'(rx_en);
    if (hit(reg_addr, OFS_MAC_SET) || hit(reg_addr, OFS_MAC_CLR)) rd_mux = DATA_W'(mac_en);
    if (hit(reg_addr, OFS_VECTOR))                                rd_mux = vec;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  AST_EOI_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    eoi |-> reg_wr);                                               // R8
  AST_RD_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_addr > ADDR_W'(OFS_EOI)) |=> (rdata == '0));              // R10
endmodule

// File: rtl/mac_irq_vector.sv
module mac_irq_vector
  import mivu_pkg::*;
#(
  parameter int unsigned N_CH   = 8,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_CH-1:0]   tx_done_evt,
  input  logic [N_CH-1:0]   rx_done_evt,
  input  logic [N_CH-1:0]   tx_done_ack,
  input  logic [N_CH-1:0]   rx_done_ack,
  input  logic              host_err_evt,
  input  logic              status_evt,
  input  logic              host_err_ack,
  input  logic              status_ack,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [N_CH-1:0]   reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int unsigned CH_IW = (N_CH > 1) ? $clog2(N_CH) : 1;

  logic [N_CH-1:0]     tx_set, tx_clr, rx_set, rx_clr;
  logic [MAC_SRCS-1:0] mac_set, mac_clr;
  logic                eoi;
  logic [N_CH-1:0]     tx_pend, tx_en, tx_live;
  logic [N_CH-1:0]     rx_pend, rx_en, rx_live;
  logic [MAC_SRCS-1:0] mac_pend, mac_en, mac_live;
  logic                tx_any, rx_any;
  logic [CH_IW-1:0]    tx_idx, rx_idx;
  logic [DATA_W-1:0]   vec;
  logic                any_live;
  logic                irq_q;

  mivu_src_bank #(.W(N_CH)) u_tx (
    .clk(clk), .rst(rst), .evt(tx_done_evt), .ack(tx_done_ack),
    .en_set(tx_set), .en_clr(tx_clr),
    .pend_o(tx_pend), .en_o(tx_en), .live_o(tx_live));

  mivu_src_bank #(.W(N_CH)) u_rx (
    .clk(clk), .rst(rst), .evt(rx_done_evt), .ack(rx_done_ack),
    .en_set(rx_set), .en_clr(rx_clr),
    .pend_o(rx_pend), .en_o(rx_en), .live_o(rx_live));

  mivu_src_bank #(.W(MAC_SRCS)) u_mac (
    .clk(clk), .rst(rst),
    .evt({status_evt, host_err_evt}), .ack({status_ack, host_err_ack}),
    .en_set(mac_set), .en_clr(mac_clr),
    .pend_o(mac_pend), .en_o(mac_en), .live_o(mac_live));

  mivu_lowest #(.W(N_CH), .IW(CH_IW)) u_tx_pick (
    .req(tx_live), .found(tx_any), .idx(tx_idx));

  mivu_lowest #(.W(N_CH), .IW(CH_IW)) u_rx_pick (
    .req(rx_live), .found(rx_any), .idx(rx_idx));

  always_comb begin
    vec                     = '0;
    vec[VB_TX]              = tx_any;
    vec[VB_RX]              = rx_any;
    vec[VB_HOST]            = mac_live[0];
    vec[VB_STAT]            = mac_live[1];
    vec[VB_TXCH +: CH_IW]   = tx_idx;
    vec[VB_RXCH +: CH_IW]   = rx_idx;
  end

  assign any_live = tx_any | rx_any | (|mac_live);

  mivu_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_CH(N_CH)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .tx_en(tx_en), .rx_en(rx_en), .mac_en(mac_en),
    .vec(vec), .tx_set(tx_set), .tx_clr(tx_clr), .rx_set(rx_set),
    .rx_clr(rx_clr), .mac_set(mac_set), .mac_clr(mac_clr), .eoi(eoi),
    .rdata(reg_rdata));

  always_ff @(posedge clk) begin
    if (rst)       irq_q <= 1'b0;
    else if (eoi)  irq_q <= 1'b0;
    else           irq_q <= irq_q | any_live;
  end
  assign irq = irq_q;

  AST_EOI_DROPS: assert property (@(posedge clk) disable iff (rst)
    eoi |=> !irq);                                                 // R8
  AST_IRQ_LATCHED: assert property (@(posedge clk) disable iff (rst)
    (irq && !eoi) |=> irq);                                        // R7
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(any_live));                               // R7
  AST_TX_PICK_PENDING: assert property (@(posedge clk) disable iff (rst)
    tx_any |-> (tx_pend[tx_idx] && tx_en[tx_idx]));                // R5
  AST_TX_PICK_LOWEST: assert property (@(posedge clk) disable iff (rst)
    tx_any |-> ((tx_live & ((N_CH'(1) << tx_idx) - N_CH'(1))) == '0)); // R5
  AST_RX_PICK_LOWEST: assert property (@(posedge clk) disable iff (rst)
    rx_any |-> ((rx_live & ((N_CH'(1) << rx_idx) - N_CH'(1))) == '0)); // R5
  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (rst)
    ((tx_pend & tx_en) == '0 && (rx_pend & rx_en) == '0 &&
     (mac_pend & mac_en) == '0) |-> (vec == '0));                  // R6
endmodule

// File: tb/tb_mac_irq_vector.sv
module tb_mac_irq_vector;
  localparam int N_CH = 8;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rst;
  logic [N_CH-1:0] tx_done_evt, rx_done_evt, tx_done_ack, rx_done_ack;
  logic host_err_evt, status_evt, host_err_ack, status_ack;
  logic reg_wr;
  logic [ADDR_W-1:0] reg_addr;
  logic [N_CH-1:0] reg_wdata;
  logic [DATA_W-1:0] reg_rdata;
  logic irq;

  always #2 clk = ~clk;

  mac_irq_vector #(.N_CH(N_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst), .tx_done_evt(tx_done_evt), .rx_done_evt(rx_done_evt),
    .tx_done_ack(tx_done_ack), .rx_done_ack(rx_done_ack),
    .host_err_evt(host_err_evt), .status_evt(status_evt),
    .host_err_ack(host_err_ack), .status_ack(status_ack),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq));

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // tx_evt, rx_evt, mac_evt, tx_en, rx_en, mac_en, expected vector, expected irq
  localparam logic [68:0] TV [0:8] = '{
    {8'h08, 8'h00, 2'b00, 8'hFF, 8'hFF, 2'b11, 32'h0001_0003, 1'b1},
    {8'h00, 8'h40, 2'b00, 8'hFF, 8'hFF, 2'b11, 32'h0002_0600, 1'b1},
    {8'hA0, 8'h06, 2'b00, 8'hFF, 8'hFF, 2'b11, 32'h0003_0105, 1'b1},
    {8'h00, 8'h00, 2'b01, 8'hFF, 8'hFF, 2'b11, 32'h0004_0000, 1'b1},
    {8'h00, 8'h00, 2'b10, 8'hFF, 8'hFF, 2'b11, 32'h0008_0000, 1'b1},
    {8'h03, 8'h00, 2'b00, 8'hFE, 8'hFF, 2'b11, 32'h0001_0001, 1'b1},
    {8'h01, 8'h01, 2'b11, 8'h00, 8'h00, 2'b00, 32'h0000_0000, 1'b0},
    {8'hFF, 8'h80, 2'b11, 8'h80, 8'h80, 2'b10, 32'h000B_0707, 1'b1},
    {8'h00, 8'hFF, 2'b00, 8'h00, 8'hF0, 2'b00, 32'h0002_0400, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic ack_all();
    @(negedge clk);
    tx_done_ack = '1; rx_done_ack = '1; host_err_ack = 1'b1; status_ack = 1'b1;
    @(negedge clk);
    tx_done_ack = '0; rx_done_ack = '0; host_err_ack = 1'b0; status_ack = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] t, input logic [7:0] r, input logic [1:0] m);
    @(negedge clk);
    tx_done_evt = t; rx_done_evt = r; {status_evt, host_err_evt} = m;
    @(negedge clk);
    tx_done_evt = '0; rx_done_evt = '0; {status_evt, host_err_evt} = 2'b00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    tx_done_evt = '0; rx_done_evt = '0; tx_done_ack = '0; rx_done_ack = '0;
    host_err_evt = 0; status_evt = 0; host_err_ack = 0; status_ack = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(4'h6, d); chk("R1 vector", d, 32'h0);
    rd(4'h0, d); chk("R1 tx mask", d, 32'h0);
    rd(4'h4, d); chk("R1 mac mask", d, 32'h0);

    // Main table: R4 R5 R6
    for (int i = 0; i < 9; i++) begin
      ack_all();
      wr(4'h7, 8'h00);
      wr(4'h1, 8'hFF); wr(4'h3, 8'hFF); wr(4'h5, 8'hFF);
      wr(4'h0, TV[i][50:43]); wr(4'h2, TV[i][42:35]); wr(4'h4, {6'b0, TV[i][34:33]});
      pulse(TV[i][68:61], TV[i][60:53], TV[i][52:51]);
      @(negedge clk);
      chk("R7 table irq", {31'b0, irq}, {31'b0, TV[i][0]});
      rd(4'h6, d);
      chk("R4 R5 R6 table vector", d, TV[i][32:1]);
    end

    // R2 mask set/clear and readback
    ack_all(); wr(4'h7, 8'h00);
    wr(4'h1, 8'hFF);
    wr(4'h0, 8'h0F); wr(4'h0, 8'h30);
    rd(4'h0, d); chk("R2 tx mask OR", d, 32'h3F);
    wr(4'h1, 8'h05);
    rd(4'h1, d); chk("R2 tx mask clear", d, 32'h3A);
    wr(4'h3, 8'hFF); wr(4'h2, 8'h81);
    rd(4'h3, d); chk("R2 rx mask", d, 32'h81);

    // R9 full clear and MAC width
    wr(4'h1, 8'hFF);
    rd(4'h0, d); chk("R9 tx cleared", d, 32'h0);
    wr(4'h4, 8'hFF);
    rd(4'h4, d); chk("R9 mac width", d, 32'h3);
    wr(4'h5, 8'hFF);
    rd(4'h5, d); chk("R9 mac cleared", d, 32'h0);

    // R10 unmapped address
    rd(4'hC, d); chk("R10 unmapped", d, 32'h0);

    // R3 event wins over ack
    wr(4'h3, 8'hFF);
    wr(4'h0, 8'hFF);
    @(negedge clk);
    tx_done_evt = 8'h04; tx_done_ack = 8'h04;
    @(negedge clk);
    tx_done_evt = '0; tx_done_ack = '0;
    rd(4'h6, d); chk("R3 event wins", d, 32'h0001_0002);
    @(negedge clk); tx_done_ack = 8'h04;
    @(negedge clk); tx_done_ack = '0;
    rd(4'h6, d); chk("R3 ack clears", d, 32'h0);
    wr(4'h7, 8'h00);

    // R6 disabled then enabled
    wr(4'h1, 8'hFF);
    pulse(8'h10, 8'h00, 2'b00);
    @(negedge clk);
    chk("R6 masked irq", {31'b0, irq}, 32'h0);
    rd(4'h6, d); chk("R6 masked vector", d, 32'h0);
    wr(4'h0, 8'h10);
    @(negedge clk);
    chk("R6 enabled irq", {31'b0, irq}, 32'h1);
    rd(4'h6, d); chk("R6 enabled vector", d, 32'h0001_0004);

    // R7 hold after ack
    @(negedge clk); tx_done_ack = 8'h10;
    @(negedge clk); tx_done_ack = '0;
    @(negedge clk);
    chk("R7 held", {31'b0, irq}, 32'h1);
    rd(4'h6, d); chk("R7 vector empty", d, 32'h0);
    wr(4'h7, 8'h00);
    chk("R8 drop", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R8 stays low", {31'b0, irq}, 32'h0);

    // R8 re-rise with pending work
    pulse(8'h10, 8'h00, 2'b00);
    @(negedge clk);
    chk("R8 pending irq", {31'b0, irq}, 32'h1);
    wr(4'h7, 8'hA5);
    chk("R8 dip", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R8 re-rise", {31'b0, irq}, 32'h1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule